// File: doc/BRIEF.md
# Calendar Real-Time Clock with Write-Locked Time Registers

This peripheral keeps wall-clock time as separate calendar fields (second, minute, hour, day of month, month, year within the century, century) rather than as one binary count. Firmware reaches it over a simple 32-bit register bus: a write strobe, a byte address, write data and combinational read data. Two time words carry the fields. Two scratch words, named alarm and alarm status, only hold what is written to them. One control word carries a run bit and a write-enable bit for the time words.

A one-second pulse on `sec_tick` advances the time when the run bit is set. The carry runs from seconds through minutes, hours, days, months and years into the century. Month lengths follow the calendar. February has 29 days when the full year (century × 100 + year) is a multiple of 4.

The control word is held by a four-state machine. The states are HALT_LOCKED (stopped, time writes refused; the reset state), HALT_OPEN (stopped, time writes accepted), RUN_LOCKED (counting, time writes refused) and RUN_OPEN (counting, time writes accepted). A write to the control word takes the transition that its two low bits select. The transitions are named *stop-seal* (to HALT_LOCKED), *stop-open* (to HALT_OPEN), *run-seal* (to RUN_LOCKED) and *run-open* (to RUN_OPEN). They can be taken from any state. With no control write, the state holds.

Top module: `cal_rtc`

## Requirements
- R1: After reset, every word reads zero: both time words, alarm, alarm status and control. The machine starts in HALT_LOCKED.
- R2: The word is chosen by `bus_addr[ADDR_W-1:2]`: time word A at byte 0x00, time word B at 0x04, alarm at 0x08, control at 0x10 and alarm status at 0x14. Byte offset 0x0C and any offset at or above 0x18 read zero, and writes to them have no effect.
- R3: Time word A holds second in bits 5:0, minute in bits 13:8, hour in bits 20:16 and day in bits 28:24. Time word B holds month in bits 3:0, year in bits 14:8 and century in bits 20:16. All other bits read zero.
- R4: In the control word, bit 0 is the run bit and bit 1 is the time-write enable. Bits 31:2 read zero. A control write moves the machine to the state that bits 1:0 select.
- R5: A write to either time word while the write enable is clear is discarded.
- R6: A write to a time word while the write enable is set replaces that word's fields on the next clock edge. The other time word is not changed.
- R7: A `sec_tick` pulse advances the second only while the run bit is set. Ticks while the run bit is clear are ignored. Reads always return the current time.
- R8: A second at or above 59 becomes 0 and carries into the minute. A minute at or above 59 becomes 0 and carries into the hour. An hour at or above 23 becomes 0 and carries into the day.
- R9: A day at or above the month's length becomes 1 and carries into the month. The length is 30 for months 4, 6, 9 and 11, the February rule for month 2, and 31 for every other month code.
- R10: February has 29 days when (century × 100 + year) is divisible by 4, and 28 days otherwise.
- R11: A month at or above 12 becomes 1 and carries into the year.
- R12: A year at or above 99 becomes 0 and increments the century in the same edge. The century wraps from 31 to 0.
- R13: When an accepted time-word write and a counted tick fall in the same cycle, the write is applied and the tick is dropped for both time words.
- R14: The alarm and alarm status words store and return all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
The bench builds the block with its default `ADDR_W` of 5. This makes the unused word at 0x0C and the two words past the map (0x18, 0x1C) addressable, so the zero-read and write-ignore behaviour of holes can be checked. Because the time words can be loaded with any field value, each rollover is one write and one tick away. The random stimulus loads values just below each limit, and also out-of-range values such as hour 30, month 15 or year 120, so the at-or-above wrap rules are exercised without waiting through long count sequences.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 7;
    localparam int CENT_W = 5;

    localparam int WD_TIME_A = 0;
    localparam int WD_TIME_B = 1;
    localparam int WD_ALARM  = 2;
    localparam int WD_CTRL   = 4;
    localparam int WD_STAT   = 5;

    typedef enum logic [1:0] {
        CS_HALT_LOCKED = 2'b00,
        CS_RUN_LOCKED  = 2'b01,
        CS_HALT_OPEN   = 2'b10,
        CS_RUN_OPEN    = 2'b11
    } ctrl_state_t;

    function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] mon,
                                                   input logic leap);
        logic [DAY_W-1:0] len;
        case (mon)
            4'd2:                      len = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   len = 5'd30;
            default:                   len = 5'd31;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/rtc_digit.sv
module rtc_digit #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    input  logic [W-1:0] limit,
    input  logic [W-1:0] wrap_to,
    output logic [W-1:0] val,
    output logic         at_limit
);

    assign at_limit = (val >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= '0;
        end else if (load) begin
            val <= load_val;
        end else if (inc) begin
            val <= at_limit ? wrap_to : val + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_a,
    input  logic        load_b,
    input  logic        advance,
    input  logic [31:0] wdata,
    output logic [31:0] word_a,
    output logic [31:0] word_b
);

    logic [SEC_W-1:0]  sec_q;
    logic [MIN_W-1:0]  min_q;
    logic [HOUR_W-1:0] hour_q;
    logic [DAY_W-1:0]  day_q;
    logic [MON_W-1:0]  mon_q;
    logic [YEAR_W-1:0] year_q;
    logic [CENT_W-1:0] cent_q;

    logic sec_top, min_top, hour_top, day_top, mon_top, year_top, cent_top;
    logic inc_min, inc_hour, inc_day, inc_mon, inc_year, inc_cent;
    logic [DAY_W-1:0] day_limit;
    logic unused_cent_top;

    // Full year = century*100 + year; 100 is a multiple of 4, so only year matters.
    assign day_limit = month_len(mon_q, (year_q[1:0] == 2'b00));

    assign inc_min  = advance  & sec_top;
    assign inc_hour = inc_min  & min_top;
    assign inc_day  = inc_hour & hour_top;
    assign inc_mon  = inc_day  & day_top;
    assign inc_year = inc_mon  & mon_top;
    assign inc_cent = inc_year & year_top;
    assign unused_cent_top = cent_top;

    rtc_digit #(.W(SEC_W)) u_sec (
        .clk(clk), .rst_n(rst_n), .load(load_a), .load_val(wdata[5:0]),
        .inc(advance), .limit(6'd59), .wrap_to(6'd0), .val(sec_q), .at_limit(sec_top));

    rtc_digit #(.W(MIN_W)) u_min (
        .clk(clk), .rst_n(rst_n), .load(load_a), .load_val(wdata[13:8]),
        .inc(inc_min), .limit(6'd59), .wrap_to(6'd0), .val(min_q), .at_limit(min_top));

    rtc_digit #(.W(HOUR_W)) u_hour (
        .clk(clk), .rst_n(rst_n), .load(load_a), .load_val(wdata[20:16]),
        .inc(inc_hour), .limit(5'd23), .wrap_to(5'd0), .val(hour_q), .at_limit(hour_top));

    rtc_digit #(.W(DAY_W)) u_day (
        .clk(clk), .rst_n(rst_n), .load(load_a), .load_val(wdata[28:24]),
        .inc(inc_day), .limit(day_limit), .wrap_to(5'd1), .val(day_q), .at_limit(day_top));

    rtc_digit #(.W(MON_W)) u_mon (
        .clk(clk), .rst_n(rst_n), .load(load_b), .load_val(wdata[3:0]),
        .inc(inc_mon), .limit(4'd12), .wrap_to(4'd1), .val(mon_q), .at_limit(mon_top));

    rtc_digit #(.W(YEAR_W)) u_year (
        .clk(clk), .rst_n(rst_n), .load(load_b), .load_val(wdata[14:8]),
        .inc(inc_year), .limit(7'd99), .wrap_to(7'd0), .val(year_q), .at_limit(year_top));

    rtc_digit #(.W(CENT_W)) u_cent (
        .clk(clk), .rst_n(rst_n), .load(load_b), .load_val(wdata[20:16]),
        .inc(inc_cent), .limit(5'd31), .wrap_to(5'd0), .val(cent_q), .at_limit(cent_top));

    assign word_a = {3'b0, day_q, 3'b0, hour_q, 2'b0, min_q, 2'b0, sec_q};
    assign word_b = {11'b0, cent_q, 1'b0, year_q, 4'b0, mon_q};

endmodule

// File: rtl/rtc_ctrl_fsm.sv
module rtc_ctrl_fsm
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_req,
    output logic       run,
    output logic       open
);

    ctrl_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CS_HALT_LOCKED;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        if (ctrl_wr) begin
            unique case (ctrl_req)
                2'b00: state_nxt = CS_HALT_LOCKED; // stop-seal
                2'b01: state_nxt = CS_RUN_LOCKED;  // run-seal
                2'b10: state_nxt = CS_HALT_OPEN;   // stop-open
                2'b11: state_nxt = CS_RUN_OPEN;    // run-open
            endcase
        end
    end

    always_comb begin
        unique case (state)
            CS_HALT_LOCKED: begin run = 1'b0; open = 1'b0; end
            CS_RUN_LOCKED:  begin run = 1'b1; open = 1'b0; end
            CS_HALT_OPEN:   begin run = 1'b0; open = 1'b1; end
            CS_RUN_OPEN:    begin run = 1'b1; open = 1'b1; end
        endcase
    end

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic sel_a, sel_b, sel_alarm, sel_ctrl, sel_stat;
    logic run, open;
    logic load_a, load_b, advance;
    logic [31:0] cnt1_word, cnt2_word;
    logic [31:0] alarm_q, stat_q;
    logic unused_addr_lo;

    assign word           = bus_addr[ADDR_W-1:2];
    assign unused_addr_lo = ^bus_addr[1:0];

    assign sel_a     = (word == WORD_W'(WD_TIME_A));
    assign sel_b     = (word == WORD_W'(WD_TIME_B));
    assign sel_alarm = (word == WORD_W'(WD_ALARM));
    assign sel_ctrl  = (word == WORD_W'(WD_CTRL));
    assign sel_stat  = (word == WORD_W'(WD_STAT));

    assign load_a  = bus_we & open & sel_a;
    assign load_b  = bus_we & open & sel_b;
    assign advance = sec_tick & run & ~load_a & ~load_b;

    rtc_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (bus_we & sel_ctrl),
        .ctrl_req (bus_wdata[1:0]),
        .run      (run),
        .open     (open)
    );

    rtc_calendar u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_a  (load_a),
        .load_b  (load_b),
        .advance (advance),
        .wdata   (bus_wdata),
        .word_a  (cnt1_word),
        .word_b  (cnt2_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
            stat_q  <= '0;
        end else if (bus_we) begin
            if (sel_alarm) alarm_q <= bus_wdata;
            if (sel_stat)  stat_q  <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_a)     bus_rdata = cnt1_word;
        if (sel_b)     bus_rdata = cnt2_word;
        if (sel_alarm) bus_rdata = alarm_q;
        if (sel_ctrl)  bus_rdata = {30'b0, open, run};
        if (sel_stat)  bus_rdata = stat_q;
    end

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              run,
    input logic              open,
    input logic [31:0]       cnt1,
    input logic [31:0]       cnt2
);

    localparam int WORD_W = ADDR_W - 2;
    localparam logic [31:0] MASK_A = 32'h1F1F_3F3F;
    localparam logic [31:0] MASK_B = 32'h001F_7F0F;

    logic [WORD_W-1:0] word;
    logic time_wr_ok;
    assign word       = bus_addr[ADDR_W-1:2];
    assign time_wr_ok = bus_we & open & (word < WORD_W'(2));

    a_r2_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word == WORD_W'(3)) |-> (bus_rdata == 32'h0));

    a_r5_locked_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !open && word == WORD_W'(0) && !(sec_tick && run)) |=> $stable(cnt1));

    a_r6_open_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && open && word == WORD_W'(1)) |=> (cnt2 == ($past(bus_wdata) & MASK_B)));

    a_r7_halted_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !time_wr_ok) |=> ($stable(cnt1) && $stable(cnt2)));

    a_r8_second_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && run && !time_wr_ok) |=> (cnt1[5:0] <= 6'd59));

    a_r13_write_beats_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && run && bus_we && open && word == WORD_W'(0)) |=>
            ((cnt1 == ($past(bus_wdata) & MASK_A)) && $stable(cnt2)));

endmodule

bind cal_rtc rtc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .run       (run),
    .open      (open),
    .cnt1      (cnt1_word),
    .cnt2      (cnt2_word)
);

// File: tb/cal_rtc_bench.sv
module cal_rtc_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference state
    int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_cent;
    logic [31:0] m_alarm, m_stat;
    bit m_run, m_open;

    always #2 clk = ~clk;

    cal_rtc #(.ADDR_W(5)) u_cal_rtc (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    function automatic int mdays(int mon, int yr, int cent);
        int full;
        full = cent * 100 + yr;
        if (mon == 2) return (full % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] m_read(logic [4:0] a);
        case (a[4:2])
            3'd0: return {3'b0, 5'(m_day), 3'b0, 5'(m_hr), 2'b0, 6'(m_min), 2'b0, 6'(m_sec)};
            3'd1: return {11'b0, 5'(m_cent), 1'b0, 7'(m_yr), 4'b0, 4'(m_mon)};
            3'd2: return m_alarm;
            3'd4: return {30'b0, m_open, m_run};
            3'd5: return m_stat;
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_reset();
        m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_mon = 0; m_yr = 0; m_cent = 0;
        m_alarm = '0; m_stat = '0; m_run = 0; m_open = 0;
    endtask

    task automatic m_tick();
        if (m_sec >= 59) begin
            m_sec = 0;
            if (m_min >= 59) begin
                m_min = 0;
                if (m_hr >= 23) begin
                    m_hr = 0;
                    if (m_day >= mdays(m_mon, m_yr, m_cent)) begin
                        m_day = 1;
                        if (m_mon >= 12) begin
                            m_mon = 1;
                            if (m_yr >= 99) begin
                                m_yr = 0;
                                m_cent = (m_cent + 1) % 32;
                            end else m_yr++;
                        end else m_mon++;
                    end else m_day++;
                end else m_hr++;
            end else m_min++;
        end else m_sec++;
    endtask

    task automatic m_step(bit we, logic [4:0] a, logic [31:0] wd, bit tk);
        bit load;
        load = we && m_open && (a[4:2] == 3'd0 || a[4:2] == 3'd1);
        if (load) begin
            if (a[4:2] == 3'd0) begin
                m_sec = wd[5:0]; m_min = wd[13:8]; m_hr = wd[20:16]; m_day = wd[28:24];
            end else begin
                m_mon = wd[3:0]; m_yr = wd[14:8]; m_cent = wd[20:16];
            end
        end else if (tk && m_run) m_tick();
        if (we) begin
            if (a[4:2] == 3'd2) m_alarm = wd;
            if (a[4:2] == 3'd5) m_stat = wd;
            if (a[4:2] == 3'd4) begin m_run = wd[0]; m_open = wd[1]; end
        end
    endtask

    task automatic step(bit we, logic [4:0] a, logic [31:0] wd, bit tk);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd; sec_tick = tk;
        @(posedge clk);
        m_step(we, a, wd, tk);
    endtask

    task automatic check(logic [4:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_we = 0; sec_tick = 0; bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            failures++;
            $display("FAIL %s addr=%h got=%h exp=%h", tag, a, bus_rdata, exp);
        end
    endtask

    function automatic logic [31:0] pack_a(int d, int h, int mi, int s);
        return {3'b0, 5'(d), 3'b0, 5'(h), 2'b0, 6'(mi), 2'b0, 6'(s)};
    endfunction

    function automatic logic [31:0] pack_b(int c, int y, int mo);
        return {11'b0, 5'(c), 1'b0, 7'(y), 4'b0, 4'(mo)};
    endfunction

    function automatic int pick(int edge_v, int span);
        return ($urandom % 2 == 0) ? edge_v : int'($urandom % span);
    endfunction

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset values
        for (int w = 0; w < 8; w++) check(5'(w * 4), 32'h0, "R1 reset");

        // R5: locked write discarded
        step(1, 5'h00, pack_a(5, 6, 7, 8), 0);
        check(5'h00, 32'h0, "R5 locked write");

        // R4: control bits, upper bits read zero; open without running
        step(1, 5'h10, 32'hFFFF_FFFE, 0);
        check(5'h10, 32'h2, "R4 control");

        // R6: load one word, other word untouched
        step(1, 5'h00, 32'hFFFF_FFFF & pack_a(31, 23, 59, 59) | 32'hE0E0_C0C0, 0);
        check(5'h00, pack_a(31, 23, 59, 59), "R3 field mask");
        check(5'h04, 32'h0, "R6 other word kept");
        step(1, 5'h04, pack_b(20, 99, 12), 0);
        check(5'h04, pack_b(20, 99, 12), "R6 load word B");

        // R7: tick while halted ignored
        step(0, 5'h00, 0, 1);
        check(5'h00, pack_a(31, 23, 59, 59), "R7 halted tick");

        // full carry chain
        step(1, 5'h10, 32'h3, 0);
        step(0, 5'h00, 0, 1);
        check(5'h00, pack_a(1, 0, 0, 0), "R8 carry to day");
        check(5'h04, pack_b(21, 0, 1), "R12 year to century");

        // R10: leap February
        step(1, 5'h04, pack_b(20, 24, 2), 0);
        step(1, 5'h00, pack_a(28, 23, 59, 59), 1);
        check(5'h00, pack_a(28, 23, 59, 59), "R13 write beats tick");
        step(0, 5'h00, 0, 1);
        check(5'h00, pack_a(29, 0, 0, 0), "R10 leap day 29");
        step(1, 5'h00, pack_a(29, 23, 59, 59), 0);
        step(0, 5'h00, 0, 1);
        check(5'h04, pack_b(20, 24, 3), "R10 leap end of Feb");
        step(1, 5'h04, pack_b(20, 23, 2), 0);
        step(1, 5'h00, pack_a(28, 23, 59, 59), 0);
        step(0, 5'h00, 0, 1);
        check(5'h00, pack_a(1, 0, 0, 0), "R10 common Feb");
        check(5'h04, pack_b(20, 23, 3), "R9 month carry");
        step(1, 5'h04, pack_b(20, 23, 4), 0);
        step(1, 5'h00, pack_a(30, 23, 59, 59), 0);
        step(0, 5'h00, 0, 1);
        check(5'h04, pack_b(20, 23, 5), "R9 30-day month");
        step(1, 5'h04, pack_b(31, 99, 12), 0);
        step(1, 5'h00, pack_a(31, 23, 59, 59), 0);
        step(0, 5'h00, 0, 1);
        check(5'h04, pack_b(0, 0, 1), "R11 R12 century wrap");

        // R14 and R2
        step(1, 5'h08, 32'hDEAD_BEEF, 0);
        step(1, 5'h14, 32'h1234_5678, 0);
        step(1, 5'h0C, 32'hFFFF_FFFF, 0);
        step(1, 5'h18, 32'hFFFF_FFFF, 0);
        check(5'h08, 32'hDEAD_BEEF, "R14 alarm");
        check(5'h17, 32'h1234_5678, "R14 status");
        check(5'h0C, 32'h0, "R2 hole");
        check(5'h1C, 32'h0, "R2 past map");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int kind;
            logic [4:0] a;
            logic [31:0] wd;
            kind = int'($urandom % 8);
            a = 5'($urandom);
            wd = $urandom;
            if (kind == 0) begin a = 5'h10; wd[1:0] = ($urandom % 4 == 0) ? 2'b01 : 2'b11; end
            if (kind == 1 || kind == 2) begin
                a = 5'h00 | 5'($urandom % 4);
                wd = pack_a(pick(28 + int'($urandom % 4), 32), pick(23, 32), pick(59, 64), pick(59, 64));
            end
            if (kind == 3) begin
                a = 5'h04;
                wd = pack_b(pick(31, 32), pick(99, 128), ($urandom % 2 == 0) ? 2 : int'($urandom % 16));
            end
            step(kind < 5, a, wd, $urandom % 2 == 0);
            if (kind >= 3) step(0, 5'h00, 0, 1);
            a = 5'($urandom);
            check(a, m_read(a), (a[4:2] < 3'd2) ? "R8 R9 random time" : "R2 random word");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        done = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule